// File: doc/BRIEF.md
# Serial PCM Audio Receiver

This block takes a two-channel serial PCM stream arriving on three external lines (bit clock, word-select and data) and turns it into parallel audio words in the system clock domain. The three lines are oversampled: each one passes through a synchronizer, and the chosen edge of the bit clock is found by comparing consecutive synchronized levels. Every bit-clock sample then drives one shared deserializer. A word is emitted as soon as it is complete, together with a flag that tells whether it belongs to the left or the right channel.

Three framing conventions share the deserializer. In the I2S-style framing the first bit lags the word-select change by one bit period. In the start-aligned framing the first bit coincides with that change. In the end-aligned framing the last bit sits just before the next change. The start-aligned and end-aligned framings use the opposite channel polarity to I2S. The framing, the sampling edge and the word length are static settings. They are held stable while the stream runs, and the block is reset after any change. The system clock must run at least four times faster than the bit clock.

The output is a stream that carries valid but no ready signal. The serial source cannot be paused, so there is no back-pressure. The sink must take each word in the single cycle in which `word_valid` is high. Successive words are always at least one full bit-clock period apart.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is held, and in the cycles that follow it before any word completes, `word_valid` is 0 and `word_data` is zero.
- R2: With `fmt_sel` = 0 (I2S-style framing), the MSB is the bit sampled at the second sample after a word-select change. A word carried while word-select is low is left (`word_right` = 0), and a word carried while it is high is right (`word_right` = 1).
- R3: With `fmt_sel` = 1 (start-aligned framing), the MSB is the bit sampled at the first sample after a word-select change. Word-select high means left (`word_right` = 0) and low means right (`word_right` = 1). The code 3 behaves exactly like 1.
- R4: With `fmt_sel` = 2 (end-aligned framing), the word is made of the last W bits sampled before a word-select change. The bit sampled just before the change is the LSB. Earlier bits in that half are discarded. The channel polarity is the same as in R3.
- R5: With `fall_edge` = 1 in framings 1, 2 and 3, data is sampled on falling bit-clock edges; otherwise on rising edges. In framing 0, `fall_edge` has no effect and sampling stays on the rising edge.
- R6: The word length W is `word_len`, clamped to the range 8..24. A word occupies `word_data[W-1:0]` MSB-first, and all bits above W-1 are zero.
- R7: In framings 0, 1 and 3, the samples that follow the W-th data bit of a half are ignored until the next word-select change.
- R8: In framings 1 and 3, if word-select changes after only k < W data bits, the word is still emitted at that change. Its k bits occupy the top of the W-bit field, and the lower W-k bits are zero.
- R9: Each completed word raises `word_valid` for exactly one cycle, with `word_data` and `word_right` valid in that same cycle.
- R10: No word is emitted from bits that arrive before the first word-select change seen after reset.
- R11: In framing 0, when W equals the half-frame length, the final bit of one word is sampled at the same instant that the next word starts. That word is still emitted whole and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing: 0 I2S-style, 1 start-aligned, 2 end-aligned, 3 same as 1 |
| fall_edge | input | 1 | Sample on falling bit-clock edges (framings 1-3 only) |
| word_len | input | 5 | Word length W, clamped to 8..24 |
| sclk_in | input | 1 | External serial bit clock (asynchronous) |
| lrclk_in | input | 1 | External word-select line (asynchronous) |
| sdata_in | input | 1 | External serial data line (asynchronous) |
| word_valid | output | 1 | One-cycle strobe marking a completed word |
| word_right | output | 1 | Channel of the word: 1 right, 0 left |
| word_data | output | 24 | Received word, right-aligned in W bits |

## Verification
Two events can land on the same bit-clock sample: the completion of one word and the start of the next. This happens in I2S-style framing when the word length fills the whole half. It also happens in end-aligned framing, where the window register is latched at the same sample in which it shifts in the first bit of the new half. The bench provokes the first case with 24-bit words in 24-slot halves, and the second with both full and padded halves. The scoreboard then requires every word to arrive complete, in order and with the right channel flag, and it also checks that no extra word appears.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_START = 2'd1,
    FMT_END   = 2'd2,
    FMT_ALT   = 2'd3
  } rx_fmt_e;

  localparam int unsigned LINES = 3;

endpackage

// File: rtl/asrx_line_sync.sv
module asrx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_fall,
  input  logic sclk_in,
  input  logic lrclk_in,
  input  logic sdata_in,
  output logic stb,
  output logic lr_s,
  output logic sd_s
);
  import asrx_pkg::*;

  logic [LINES-1:0] stg [STAGES];
  logic             sclk_d;
  logic             sclk_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      sclk_d <= 1'b0;
    end else begin
      stg[0] <= {sclk_in, lrclk_in, sdata_in};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= sclk_s;
    end
  end

  assign sclk_s = stg[STAGES-1][2];
  assign lr_s   = stg[STAGES-1][1];
  assign sd_s   = stg[STAGES-1][0];

  generate
    if (STAGES > 0) begin : g_edge
      logic rise, fall;
      assign rise = sclk_s & ~sclk_d;
      assign fall = ~sclk_s & sclk_d;
      assign stb  = use_fall ? fall : rise;
    end
  endgenerate

  // R5
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

endmodule

// File: rtl/asrx_framer.sv
module asrx_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic lr_s,
  output logic bnd,
  output logic old_lr,
  output logic armed
);
  logic have_prev;
  logic lr_last;

  assign bnd    = stb & have_prev & (lr_s != lr_last);
  assign old_lr = lr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      lr_last   <= 1'b0;
      armed     <= 1'b0;
    end else if (stb) begin
      have_prev <= 1'b1;
      lr_last   <= lr_s;
      if (bnd) armed <= 1'b1;
    end
  end

  // R10
  armed_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(bnd));

endmodule

// File: rtl/asrx_deser.sv
module asrx_deser #(
  parameter int unsigned MAX_W = 24,
  parameter int unsigned MIN_W = 8,
  localparam int unsigned LENW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic [LENW-1:0]  wlen,
  input  logic             stb,
  input  logic             bnd,
  input  logic             armed,
  input  logic             old_lr,
  input  logic             cur_lr,
  input  logic             sd,
  output logic             out_valid,
  output logic             out_right,
  output logic [MAX_W-1:0] out_data
);
  import asrx_pkg::*;

  rx_fmt_e          mode;
  logic [LENW-1:0]  weff;
  logic [MAX_W-1:0] mask;

  logic [MAX_W-1:0] acc, acc_n, acc_sh;
  logic [MAX_W-1:0] win, win_n;
  logic [LENW-1:0]  cnt, cnt_n, cnt_inc;
  logic             active, act_n;
  logic             w_lr, wlr_n;
  logic             emit, e_lr;
  logic [MAX_W-1:0] e_data;

  assign mode = rx_fmt_e'(fmt_sel);

  always_comb begin
    if (wlen < LENW'(MIN_W))      weff = LENW'(MIN_W);
    else if (wlen > LENW'(MAX_W)) weff = LENW'(MAX_W);
    else                          weff = wlen;
  end

  assign mask    = (MAX_W'(1) << weff) - MAX_W'(1);
  assign acc_sh  = {acc[MAX_W-2:0], sd};
  assign cnt_inc = cnt + LENW'(1);

  function automatic logic [MAX_W-1:0] top_fill(input logic [MAX_W-1:0] v,
                                                input logic [LENW-1:0]  have,
                                                input logic [LENW-1:0]  want);
    return v << (want - have);
  endfunction

  always_comb begin
    acc_n  = acc;
    cnt_n  = cnt;
    act_n  = active;
    wlr_n  = w_lr;
    win_n  = win;
    emit   = 1'b0;
    e_data = '0;
    e_lr   = w_lr;
    if (stb) begin
      unique case (mode)
        FMT_END: begin
          win_n = {win[MAX_W-2:0], sd};
          if (bnd && armed) begin
            emit   = 1'b1;
            e_data = win & mask;
            e_lr   = old_lr;
          end
        end
        FMT_I2S: begin
          if (bnd) begin
            if (active && cnt < weff) begin
              emit   = 1'b1;
              e_data = top_fill(acc_sh, cnt_inc, weff);
            end
            act_n = 1'b1;
            cnt_n = '0;
            acc_n = '0;
            wlr_n = cur_lr;
          end else if (active && cnt < weff) begin
            acc_n = acc_sh;
            cnt_n = cnt_inc;
            if (cnt_inc == weff) begin
              emit   = 1'b1;
              e_data = acc_sh;
            end
          end
        end
        default: begin
          if (bnd) begin
            if (active && cnt < weff) begin
              emit   = 1'b1;
              e_data = top_fill(acc, cnt, weff);
            end
            act_n = 1'b1;
            cnt_n = LENW'(1);
            acc_n = {{(MAX_W-1){1'b0}}, sd};
            wlr_n = cur_lr;
          end else if (active && cnt < weff) begin
            acc_n = acc_sh;
            cnt_n = cnt_inc;
            if (cnt_inc == weff) begin
              emit   = 1'b1;
              e_data = acc_sh;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      win       <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      w_lr      <= 1'b0;
      out_valid <= 1'b0;
      out_right <= 1'b0;
      out_data  <= '0;
    end else begin
      acc       <= acc_n;
      win       <= win_n;
      cnt       <= cnt_n;
      active    <= act_n;
      w_lr      <= wlr_n;
      out_valid <= emit;
      if (emit) begin
        out_data  <= e_data;
        out_right <= (mode == FMT_I2S) ? e_lr : ~e_lr;
      end
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= weff);

  // R6
  data_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data >> weff) == '0));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(stb));

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int unsigned MAX_W       = 24,
  parameter int unsigned MIN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LENW       = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_sel,
  input  logic             fall_edge,
  input  logic [LENW-1:0]  word_len,
  input  logic             sclk_in,
  input  logic             lrclk_in,
  input  logic             sdata_in,
  output logic             word_valid,
  output logic             word_right,
  output logic [MAX_W-1:0] word_data
);
  import asrx_pkg::*;

  logic use_fall;
  logic stb, lr_s, sd_s;
  logic bnd, old_lr, armed;

  assign use_fall = fall_edge & (rx_fmt_e'(fmt_sel) != FMT_I2S);

  asrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_fall (use_fall),
    .sclk_in  (sclk_in),
    .lrclk_in (lrclk_in),
    .sdata_in (sdata_in),
    .stb      (stb),
    .lr_s     (lr_s),
    .sd_s     (sd_s)
  );

  asrx_framer u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .lr_s   (lr_s),
    .bnd    (bnd),
    .old_lr (old_lr),
    .armed  (armed)
  );

  asrx_deser #(.MAX_W(MAX_W), .MIN_W(MIN_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .wlen      (word_len),
    .stb       (stb),
    .bnd       (bnd),
    .armed     (armed),
    .old_lr    (old_lr),
    .cur_lr    (lr_s),
    .sd        (sd_s),
    .out_valid (word_valid),
    .out_right (word_right),
    .out_data  (word_data)
  );

endmodule

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;

  localparam int H = 4;  // system cycles per bit-clock half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        fall_edge = 1'b0;
  logic [4:0]  word_len = 5'd24;
  logic        sclk_in = 1'b0;
  logic        lrclk_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic        word_valid;
  logic        word_right;
  logic [23:0] word_data;

  int checks = 0;
  int errors = 0;
  bit last_v = 1'b0;

  typedef struct {
    bit          right;
    logic [23:0] data;
  } exp_t;

  exp_t  q[$];
  string tq[$];

  always #2 clk = ~clk;

  audio_serial_rx u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_sel    (fmt_sel),
    .fall_edge  (fall_edge),
    .word_len   (word_len),
    .sclk_in    (sclk_in),
    .lrclk_in   (lrclk_in),
    .sdata_in   (sdata_in),
    .word_valid (word_valid),
    .word_right (word_right),
    .word_data  (word_data)
  );

  // monitor: pops expected words as the design produces them
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      checks++;
      if (last_v) begin
        errors++;
        $display("FAIL R9: valid high two cycles, got 1 expected 0");
      end
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected word right=%0b data=%h, expected none",
                 word_right, word_data);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        if (e.right !== word_right || e.data !== word_data) begin
          errors++;
          $display("FAIL %s: got right=%0b data=%h, expected right=%0b data=%h",
                   t, word_right, word_data, e.right, e.data);
        end
      end
    end
    last_v = rst_n && word_valid;
  end

  task automatic run_case(input int fmt, input bit fe, input int cfg_len,
                          input int w, input int slots, input string tag,
                          input int seed);
    bit ls[$];
    bit ds[$];
    bit left_lv;
    bit samp;
    int nh = 4;
    fmt_sel   = fmt[1:0];
    fall_edge = fe;
    word_len  = cfg_len[4:0];
    samp      = (fmt != 0 && fe) ? 1'b0 : 1'b1;
    @(negedge clk);
    sclk_in  = ~samp;
    lrclk_in = 1'b0;
    sdata_in = 1'b0;
    rst_n    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    left_lv = (fmt == 0) ? 1'b0 : 1'b1;
    for (int i = 0; i < 3; i++) begin
      ls.push_back(~left_lv);
      ds.push_back(1'(((i * 5 + seed) >> 1)));
    end
    for (int k = 0; k < nh; k++) begin
      for (int s = 0; s < slots; s++) begin
        int pos = 3 + k * slots + s;
        ls.push_back((k % 2 == 0) ? left_lv : ~left_lv);
        ds.push_back(1'(((pos * 5 + seed) >> 1)));
      end
    end
    for (int i = 0; i < 2; i++) begin
      ls.push_back(left_lv);
      ds.push_back(1'(i + seed));
    end
    for (int k = 0; k < nh; k++) begin
      logic [23:0] word;
      logic [23:0] keep;
      exp_t        e;
      int start = 3 + k * slots;
      int off   = (fmt == 0) ? 1 : (fmt == 2) ? slots - w : 0;
      int lim   = (fmt == 0) ? start + slots + 1 : start + slots;
      int kb    = 0;
      word = 24'(seed * 40503 + k * 2654435 + ((k & 1) * 8388609));
      word = word & ((24'(1) << w) - 24'(1));
      for (int b = 0; b < w; b++) begin
        int pos = start + off + b;
        if (pos < lim) begin
          ds[pos] = word[w-1-b];
          kb++;
        end
      end
      keep = word & ~((24'(1) << (w - kb)) - 24'(1));
      e.right = bit'(k % 2);
      e.data  = keep;
      q.push_back(e);
      tq.push_back(tag);
    end
    for (int p = 0; p < ls.size(); p++) begin
      lrclk_in = ls[p];
      sdata_in = ds[p];
      repeat (H) @(negedge clk);
      sclk_in = samp;
      repeat (H) @(negedge clk);
      sclk_in = ~samp;
    end
    repeat (24) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d words missing, expected 0", tag, q.size());
      q.delete();
      tq.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    checks++;
    if (word_valid !== 1'b0 || word_data !== 24'd0) begin
      errors++;
      $display("FAIL R1: got valid=%0b data=%h, expected 0 and 000000",
               word_valid, word_data);
    end
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    checks++;
    if (word_valid !== 1'b0 || word_data !== 24'd0) begin
      errors++;
      $display("FAIL R1: after release got valid=%0b data=%h, expected 0 and 000000",
               word_valid, word_data);
    end
    // I2S-style, word fills the half: completion and start coincide
    run_case(0, 1'b0, 24, 24, 24, "R2/R11 i2s full half", 11);
    // I2S-style, padded half, falling-edge flag must be ignored
    run_case(0, 1'b1, 16, 16, 32, "R5/R7 i2s edge flag ignored", 23);
    // start-aligned with trailing junk slots
    run_case(1, 1'b0, 20, 20, 24, "R3/R7 start-aligned", 37);
    // start-aligned on falling edges
    run_case(1, 1'b1, 16, 16, 32, "R3/R5 start-aligned falling", 41);
    // end-aligned, full half
    run_case(2, 1'b0, 24, 24, 24, "R4 end-aligned full", 53);
    // end-aligned, leading junk bits, falling edges
    run_case(2, 1'b1, 16, 16, 32, "R4/R5/R6 end-aligned padded", 67);
    // start-aligned, half shorter than the word
    run_case(1, 1'b0, 24, 24, 20, "R8 short half", 71);
    // code 3 as start-aligned, length below the minimum clamps to 8
    run_case(3, 1'b0, 4, 8, 24, "R3/R6 alt code clamp", 89);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule